// File: doc/BRIEF.md
# Scoreboard Hazard Issue Controller

This block is the central hazard bookkeeper for a small in-order-issue, out-of-order-completion machine. The machine has a fixed pool of functional units: by default two adders, one multiplier and one divider. Decoded instructions arrive one per cycle over a valid/ready handshake. Each carries an operation class, one destination register and two source registers. The controller records which unit holds which instruction and which unit will write each architectural register. From that record it decides, every cycle, which unit starts, which units may fetch their operands, and which finished unit may retire its result.

Every hazard is handled by holding the instruction at one fixed point. A structural clash or a pending write to the same destination holds it at entry. A source still owed by an earlier producer holds it before operand fetch. A destination that an older instruction has yet to read holds it before retirement. Results are never forwarded and registers are never renamed. The functional units are outside the block. Each one starts when it sees its operand-fetch grant and pulses its done line when its result is ready.

Top module: `sb_ctrl`

## Requirements
- R1: An instruction is accepted on a clock edge where `in_valid` and `in_ready` are both high. Acceptance is strictly in arrival order, at most one per edge. In the following cycle `issue_grant` is a single pulse on the lowest-indexed free unit of the requested class. Class codes are 0 = add, 1 = mul, 2 = div. Units are numbered adders first, then multipliers, then dividers.
- R2: `in_ready` is low while every unit of the requested class is busy. A unit that retires on an edge is still counted as busy during that cycle.
- R3: `in_ready` is low while any accepted, unretired instruction targets the same destination register.
- R4: A unit gets its operand-fetch grant only when no earlier unit still owes it a source value. A producer that retires on edge E counts as delivered from edge E onward, including for an instruction accepted on that same edge. The grant for the waiting unit is decided at edge E+1 at the earliest, and `read_grant` pulses in the cycle after the deciding edge.
- R5: After its operand-fetch grant, a unit's `fu_done` pulse marks its result ready, and the unit becomes a retirement candidate on the next edge. Every accepted instruction eventually retires.
- R6: A finished unit may not retire while another busy unit has not yet fetched a source that names this unit's destination register. Sources that are waiting on this same unit's own result are excluded from that rule.
- R7: At most one unit retires per edge. Among eligible units the lowest index wins, and `wb_grant` pulses for that unit in the following cycle. Retirement frees the unit and clears the register's owner entry only if the entry still names that unit.
- R8: Reset clears all unit and register state and holds every grant output low. After reset, `in_ready` is high for any class 0 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| in_valid | input | 1 | an instruction is offered |
| in_ready | output | 1 | the offered instruction can be accepted this cycle |
| in_cls | input | 2 | operation class: 0 add, 1 mul, 2 div |
| in_dst | input | RW | destination register |
| in_src1 | input | RW | first source register |
| in_src2 | input | RW | second source register |
| fu_done | input | NU | per-unit completion pulse |
| issue_grant | output | NU | unit that accepted an instruction on the last edge |
| read_grant | output | NU | units allowed to fetch operands and start executing |
| wb_grant | output | NU | unit allowed to write its result back |

## Verification
The bench runs a long generated stream over only six registers, so that entry clashes, source waits and write-back holds occur constantly. It checks that each of these was actually hit. If a design lost the rule that a same-edge retirement counts as delivered, the waiting unit would hang, or it would wait on a unit that is already free. If a design ignored pending reads at retirement, results would retire early, which would show as a mismatch on `wb_grant`. Contention between several finished units exposes a wrong arbitration order. A unit that is miscounted as free right after it retires would show up as an early `in_ready`.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_EXEC = 2'd1,
    ST_DONE = 2'd2
  } stage_t;

  localparam logic [1:0] CLS_ADD = 2'd0;
  localparam logic [1:0] CLS_MUL = 2'd1;
  localparam logic [1:0] CLS_DIV = 2'd2;

  // Units are laid out adders first, then multipliers, then dividers.
  function automatic logic [1:0] unit_class(input int idx, input int n_add, input int n_mul);
    if (idx < n_add) return CLS_ADD;
    if (idx < n_add + n_mul) return CLS_MUL;
    return CLS_DIV;
  endfunction
endpackage

// File: rtl/sb_issue_sel.sv
module sb_issue_sel #(
  parameter int NU    = 4,
  parameter int N_ADD = 2,
  parameter int N_MUL = 1,
  parameter int UW    = 2
) (
  input  logic [NU-1:0] busy,
  input  logic [1:0]    cls,
  output logic          free_any,
  output logic [UW-1:0] pick
);
  logic [NU-1:0] cand;

  for (genvar g = 0; g < NU; g++) begin : g_cand
    assign cand[g] = !busy[g] && (cls == sb_pkg::unit_class(g, N_ADD, N_MUL));
  end

  // lowest free unit of the class
  always_comb begin
    free_any = 1'b0;
    pick     = '0;
    for (int u = NU - 1; u >= 0; u--) begin
      if (cand[u]) begin
        free_any = 1'b1;
        pick     = UW'(u);
      end
    end
  end
endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb #(
  parameter int NU = 4,
  parameter int UW = 2,
  parameter int RW = 3
) (
  input  logic [NU-1:0]         busy,
  input  logic [NU-1:0]         done,
  input  logic [NU-1:0]         pend1,
  input  logic [NU-1:0]         pend2,
  input  logic [NU-1:0]         q1_v,
  input  logic [NU-1:0]         q2_v,
  input  logic [NU-1:0][UW-1:0] q1_id,
  input  logic [NU-1:0][UW-1:0] q2_id,
  input  logic [NU-1:0][RW-1:0] src1,
  input  logic [NU-1:0][RW-1:0] src2,
  input  logic [NU-1:0][RW-1:0] dst,
  output logic                  wb_any,
  output logic [UW-1:0]         wb_id
);
  logic [NU-1:0] war_blk;
  logic [NU-1:0] elig;

  // write-after-read hold: someone still has to fetch this destination
  always_comb begin
    for (int u = 0; u < NU; u++) begin
      war_blk[u] = 1'b0;
      for (int f = 0; f < NU; f++) begin
        if (f != u && busy[f]) begin
          if (pend1[f] && src1[f] == dst[u] && !(q1_v[f] && q1_id[f] == UW'(u)))
            war_blk[u] = 1'b1;
          if (pend2[f] && src2[f] == dst[u] && !(q2_v[f] && q2_id[f] == UW'(u)))
            war_blk[u] = 1'b1;
        end
      end
      elig[u] = busy[u] && done[u] && !war_blk[u];
    end
  end

  // fixed priority, lowest index first
  always_comb begin
    wb_any = 1'b0;
    wb_id  = '0;
    for (int u = NU - 1; u >= 0; u--) begin
      if (elig[u]) begin
        wb_any = 1'b1;
        wb_id  = UW'(u);
      end
    end
  end
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl #(
  parameter int NUM_ADD  = 2,
  parameter int NUM_MUL  = 1,
  parameter int NUM_DIV  = 1,
  parameter int NUM_REGS = 8,
  localparam int NU = NUM_ADD + NUM_MUL + NUM_DIV,
  localparam int UW = (NU > 1) ? $clog2(NU) : 1,
  localparam int RW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_cls,
  input  logic [RW-1:0] in_dst,
  input  logic [RW-1:0] in_src1,
  input  logic [RW-1:0] in_src2,
  input  logic [NU-1:0] fu_done,
  output logic [NU-1:0] issue_grant,
  output logic [NU-1:0] read_grant,
  output logic [NU-1:0] wb_grant
);
  import sb_pkg::*;

  // per-unit status
  logic [NU-1:0]         busy, pend1, pend2, q1_v, q2_v, done_v, read_ok;
  logic [NU-1:0][UW-1:0] q1_id, q2_id;
  logic [NU-1:0][RW-1:0] dst_r, src1_r, src2_r;
  stage_t                stage [NU];

  // register owner table
  logic [NUM_REGS-1:0]   rs_v;
  logic [UW-1:0]         rs_id [NUM_REGS];

  logic          free_any, accept, wb_any, s1_pend, s2_pend;
  logic [UW-1:0] pick, wb_id;

  sb_issue_sel #(.NU(NU), .N_ADD(NUM_ADD), .N_MUL(NUM_MUL), .UW(UW)) u_sel (
    .busy(busy), .cls(in_cls), .free_any(free_any), .pick(pick)
  );

  sb_wb_arb #(.NU(NU), .UW(UW), .RW(RW)) u_arb (
    .busy(busy), .done(done_v), .pend1(pend1), .pend2(pend2),
    .q1_v(q1_v), .q2_v(q2_v), .q1_id(q1_id), .q2_id(q2_id),
    .src1(src1_r), .src2(src2_r), .dst(dst_r),
    .wb_any(wb_any), .wb_id(wb_id)
  );

  for (genvar g = 0; g < NU; g++) begin : g_stat
    assign done_v[g]  = busy[g] && stage[g] == ST_DONE;
    assign read_ok[g] = busy[g] && stage[g] == ST_WAIT && !q1_v[g] && !q2_v[g];
  end

  assign in_ready = free_any && !rs_v[in_dst];
  assign accept   = in_valid && in_ready;
  // a producer retiring on this edge counts as already delivered
  assign s1_pend  = rs_v[in_src1] && !(wb_any && rs_id[in_src1] == wb_id);
  assign s2_pend  = rs_v[in_src2] && !(wb_any && rs_id[in_src2] == wb_id);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= '0; pend1 <= '0; pend2 <= '0; q1_v <= '0; q2_v <= '0;
      rs_v <= '0;
      issue_grant <= '0; read_grant <= '0; wb_grant <= '0;
      for (int u = 0; u < NU; u++) stage[u] <= ST_WAIT;
    end else begin
      issue_grant <= '0;
      read_grant  <= read_ok;
      wb_grant    <= '0;
      if (wb_any) wb_grant[wb_id] <= 1'b1;
      for (int u = 0; u < NU; u++) begin
        if (read_ok[u]) begin
          stage[u] <= ST_EXEC;
          pend1[u] <= 1'b0;
          pend2[u] <= 1'b0;
        end else if (busy[u] && stage[u] == ST_EXEC && fu_done[u]) begin
          stage[u] <= ST_DONE;
        end
        if (wb_any && q1_v[u] && q1_id[u] == wb_id) q1_v[u] <= 1'b0;
        if (wb_any && q2_v[u] && q2_id[u] == wb_id) q2_v[u] <= 1'b0;
        if (wb_any && wb_id == UW'(u)) busy[u] <= 1'b0;
        if (accept && pick == UW'(u)) begin
          busy[u]        <= 1'b1;
          stage[u]       <= ST_WAIT;
          dst_r[u]       <= in_dst;
          src1_r[u]      <= in_src1;
          src2_r[u]      <= in_src2;
          pend1[u]       <= 1'b1;
          pend2[u]       <= 1'b1;
          q1_v[u]        <= s1_pend;
          q2_v[u]        <= s2_pend;
          q1_id[u]       <= rs_id[in_src1];
          q2_id[u]       <= rs_id[in_src2];
          issue_grant[u] <= 1'b1;
        end
      end
      if (wb_any && rs_v[dst_r[wb_id]] && rs_id[dst_r[wb_id]] == wb_id)
        rs_v[dst_r[wb_id]] <= 1'b0;
      if (accept) begin
        rs_v[in_dst]  <= 1'b1;
        rs_id[in_dst] <= pick;
      end
    end
  end

  // R8: grants are quiet in the cycle after a reset edge
  a_r8_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (issue_grant == '0 && read_grant == '0 && wb_grant == '0));

  // R1: an accepted instruction lands in exactly one unit
  a_r1_one_issue: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> $onehot(issue_grant));

  // R7: single retirement per cycle
  a_r7_wb_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wb_grant));

  // R1: issue grant is never more than one unit
  a_r1_issue_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(issue_grant));

  for (genvar g = 0; g < NU; g++) begin : g_chk
    // R5: a unit cannot fetch operands and retire in the same cycle
    a_r5_no_read_wb: assert property (@(posedge clk) disable iff (rst)
      !(read_grant[g] && wb_grant[g]));
    // R4: operand fetch never in the cycle right after issue
    a_r4_no_read_at_issue: assert property (@(posedge clk) disable iff (rst)
      !(issue_grant[g] && read_grant[g]));
  end
endmodule

// File: tb/sb_ctrl_test.sv
module sb_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NU = 4;
  localparam int NREG = 8;
  localparam int RW = 3;
  localparam int NPROG = 240;

  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_ready;
  logic [1:0] in_cls;
  logic [RW-1:0] in_dst, in_src1, in_src2;
  logic [NU-1:0] fu_done, issue_grant, read_grant, wb_grant;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sb_ctrl uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .fu_done(fu_done), .issue_grant(issue_grant), .read_grant(read_grant),
    .wb_grant(wb_grant)
  );

  int checks = 0, failures = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // program
  int p_cls [NPROG], p_dst [NPROG], p_s1 [NPROG], p_s2 [NPROG];

  // reference model state
  int m_busy [NU], m_st [NU], m_dst [NU], m_s1 [NU], m_s2 [NU];
  int m_q1 [NU], m_q2 [NU], m_p1 [NU], m_p2 [NU];
  int m_rs [NREG];
  int idx = 0, retired = 0;
  int exp_iss = 0, exp_rd = 0, exp_wb = 0;
  int cov_struct = 0, cov_waw = 0, cov_raw = 0, cov_war = 0, cov_arb = 0;

  function automatic int cls_of(int u);
    return (u < 2) ? 0 : (u == 2) ? 1 : 2;
  endfunction

  function automatic int free_unit(int c);
    for (int u = 0; u < NU; u++) if (m_busy[u] == 0 && cls_of(u) == c) return u;
    return -1;
  endfunction

  function automatic bit m_ready(int c, int d);
    return free_unit(c) >= 0 && m_rs[d] < 0;
  endfunction

  function automatic bit war_hold(int u);
    for (int f = 0; f < NU; f++) begin
      if (f != u && m_busy[f] != 0) begin
        if (m_p1[f] != 0 && m_s1[f] == m_dst[u] && m_q1[f] != u) return 1;
        if (m_p2[f] != 0 && m_s2[f] == m_dst[u] && m_q2[f] != u) return 1;
      end
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int u = 0; u < NU; u++) begin
        m_busy[u] = 0; m_st[u] = 0; m_q1[u] = -1; m_q2[u] = -1; m_p1[u] = 0; m_p2[u] = 0;
      end
      for (int r = 0; r < NREG; r++) m_rs[r] = -1;
      exp_iss = 0; exp_rd = 0; exp_wb = 0;
    end else begin
      int w, nel, rdv, pu;
      bit acc;
      w = -1; nel = 0; rdv = 0;
      for (int u = 0; u < NU; u++) begin
        if (m_busy[u] != 0 && m_st[u] == 2) begin
          if (war_hold(u)) cov_war++;
          else begin nel++; if (w < 0) w = u; end
        end
        if (m_busy[u] != 0 && m_st[u] == 0) begin
          if (m_q1[u] < 0 && m_q2[u] < 0) rdv |= (1 << u);
          else cov_raw++;
        end
      end
      if (nel > 1) cov_arb++;
      acc = in_valid && m_ready(int'(in_cls), int'(in_dst));
      pu = free_unit(int'(in_cls));
      if (in_valid && !acc) begin
        if (m_rs[in_dst] >= 0) cov_waw++; else cov_struct++;
      end
      for (int u = 0; u < NU; u++) begin
        if (rdv[u]) begin m_st[u] = 1; m_p1[u] = 0; m_p2[u] = 0; end
        else if (m_busy[u] != 0 && m_st[u] == 1 && fu_done[u]) m_st[u] = 2;
      end
      if (w >= 0) begin
        m_busy[w] = 0;
        if (m_rs[m_dst[w]] == w) m_rs[m_dst[w]] = -1;
        for (int f = 0; f < NU; f++) begin
          if (m_q1[f] == w) m_q1[f] = -1;
          if (m_q2[f] == w) m_q2[f] = -1;
        end
        retired++;
      end
      if (acc) begin
        m_busy[pu] = 1; m_st[pu] = 0;
        m_dst[pu] = int'(in_dst); m_s1[pu] = int'(in_src1); m_s2[pu] = int'(in_src2);
        m_q1[pu] = m_rs[in_src1]; m_q2[pu] = m_rs[in_src2];
        m_p1[pu] = 1; m_p2[pu] = 1;
        m_rs[in_dst] = pu;
        idx++;
      end
      exp_iss = acc ? (1 << pu) : 0;
      exp_rd  = rdv;
      exp_wb  = (w >= 0) ? (1 << w) : 0;
    end
  end

  // fixed-latency functional unit stubs
  int cnt [NU];
  always @(negedge clk) begin
    for (int u = 0; u < NU; u++) begin
      if (rst) begin cnt[u] = 0; fu_done[u] = 1'b0; end
      else begin
        if (read_grant[u]) cnt[u] = (u < 2) ? 2 : (u == 2) ? 4 : 7;
        if (cnt[u] > 0) begin cnt[u]--; fu_done[u] = (cnt[u] == 0); end
        else fu_done[u] = 1'b0;
      end
    end
  end

  initial begin
    int lfsr, cyc;
    lfsr = 16'hACE1;
    for (int i = 0; i < NPROG; i++) begin
      for (int k = 0; k < 9; k++) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]} & 16'hFFFF;
      p_cls[i] = (lfsr % 3);
      p_dst[i] = (lfsr >> 3) % 6;
      p_s1[i]  = (lfsr >> 6) % 6;
      p_s2[i]  = (lfsr >> 10) % 6;
    end
    rst = 1'b1; in_valid = 1'b0; in_cls = 2'd0; in_dst = '0; in_src1 = '0; in_src2 = '0;
    repeat (3) @(negedge clk);
    check(issue_grant == 0 && read_grant == 0 && wb_grant == 0, "R8 grants in reset",
          int'({issue_grant, read_grant, wb_grant}), 0);
    for (int c = 0; c < 3; c++) begin
      in_cls = 2'(c); in_dst = 3'(c);
      #1;
      check(in_ready == 1'b1, "R8 ready after reset", int'(in_ready), 1);
    end
    rst = 1'b0;
    cyc = 0;
    while (!(idx == NPROG && retired == NPROG)) begin
      @(negedge clk);
      cyc++;
      check(int'(issue_grant) == exp_iss, "R1 issue_grant", int'(issue_grant), exp_iss);
      check(int'(read_grant) == exp_rd, "R4 read_grant", int'(read_grant), exp_rd);
      check(int'(wb_grant) == exp_wb, "R6/R7 wb_grant", int'(wb_grant), exp_wb);
      if (idx < NPROG) begin
        in_valid = 1'b1; in_cls = 2'(p_cls[idx]); in_dst = 3'(p_dst[idx]);
        in_src1 = 3'(p_s1[idx]); in_src2 = 3'(p_s2[idx]);
      end else in_valid = 1'b0;
      #1;
      if (in_valid)
        check(in_ready == m_ready(int'(in_cls), int'(in_dst)), "R2/R3 in_ready",
              int'(in_ready), int'(m_ready(int'(in_cls), int'(in_dst))));
      if (cyc > 20000) begin
        check(1'b0, "watchdog", cyc, 20000);
        break;
      end
    end
    repeat (12) begin
      @(negedge clk);
      check(read_grant == 0 && wb_grant == 0, "R5 idle after drain",
            int'({read_grant, wb_grant}), 0);
    end
    check(retired == NPROG, "R5 all retired", retired, NPROG);
    check(cov_struct > 0, "R2 structural stall seen", cov_struct, 1);
    check(cov_waw > 0, "R3 same-destination stall seen", cov_waw, 1);
    check(cov_raw > 0, "R4 source wait seen", cov_raw, 1);
    check(cov_war > 0, "R6 write-back hold seen", cov_war, 1);
    check(cov_arb > 0, "R7 retirement contention seen", cov_arb, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule